// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block takes one 32-bit block-transfer instruction word and turns it into a run of single-word memory accesses, issuing at most one per cycle and advancing only when memory accepts. The word names a base register, a contiguous span of general registers and a four-bit selection of the frame, global, link and stack registers. It also carries three mode bits, which choose the direction of the access, whether the first access skips one word past the base, and whether the base register takes its updated value at the end.

The block reads register values and the base through a combinational register-file read port. It writes loaded words, and the updated base, through a single write port. Memory traffic uses a valid/ready request port that has a write-enable and read data returned in the accepting cycle. The block raises a one-cycle completion pulse. An encoding that asks for base update while the base is itself in the transfer list is reported as illegal, and in that case the base update is dropped.

Top module: `lsm_seq`

## Requirements
- R1: Field positions in the instruction word: first span register in bits 24:20, base register in bits 19:15, last span register in bits 14:10, special-register selection in bits 9:6. Bit 5 is 1 for store and 0 for load, bit 4 selects the one-word-skip ("before") variant, bit 3 selects decrementing addressing and bit 2 enables base update.
- R2: The transfer list holds every register i with first <= i <= last and i <= 27. Selection bit 0 adds register 31, bit 1 adds 30, bit 2 adds 29 and bit 3 adds 28, whatever the span. When first = last = 31 the span adds nothing.
- R3: Registers are transferred in ascending number order, one per accepted request, and the addresses rise by 4 between consecutive transfers. The number of accepted requests equals the list size n.
- R4: In increment mode the first address is the base when bit 4 is 0 and base+4 when bit 4 is 1.
- R5: In decrement mode the highest address is the base when bit 4 is 0 and base-4 when bit 4 is 1. The lowest address, used first, is 4*(n-1) below the highest.
- R6: A store writes each listed register's value to its address. A load writes the word returned on acceptance into the listed register. A store never uses the register write port during transfers.
- R7: With base update enabled and a legal encoding, the base register receives base+4n (increment) or base-4n (decrement) after the last transfer.
- R8: With base update enabled and the base register in the list, the illegal output is high together with the completion pulse and the base is not updated. Loads into it still take place.
- R9: While a request is valid and not accepted, it stays valid and its address and write-enable do not change.
- R10: An instruction is taken only while instr_ready is high (idle). An instruction offered while busy is ignored. done is a single-cycle pulse in the cycle after the last transfer and any base update. An empty list completes with no memory requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 32 | Block-transfer instruction |
| instr_ready | output | 1 | Idle, instruction accepted this cycle if valid |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid when accepted |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Base-in-list with update, high with done |

## Verification
The checker watches, on every cycle, that stalled requests hold their address and direction, that accepted requests step the address by 4, that done lasts one cycle and that illegal only appears with it. It also checks that stores never touch the write port and that no request is made while idle. What the accesses actually contain cannot be seen cycle by cycle. This covers the list built from span and selection bits, the start address in each of the eight mode combinations, the updated base and the suppressed update on illegal encodings. The bench sweeps those combinations against a memory and register model and compares final contents.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 32;
    localparam int REG_N    = 32;
    localparam int IDX_W    = $clog2(REG_N);
    localparam int CNT_W    = $clog2(REG_N + 1);
    localparam int SPEC_N   = 4;
    localparam int SPEC_LO  = REG_N - SPEC_N;
    localparam int STEP_B   = 4;

    typedef struct packed {
        logic             is_store;
        logic             skip_first;
        logic             down;
        logic             upd_base;
        logic [IDX_W-1:0] base_r;
        logic [IDX_W-1:0] span_lo;
        logic [IDX_W-1:0] span_hi;
        logic [SPEC_N-1:0] spec_sel;
    } lsm_op_t;

    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_BASE} lsm_state_e;

    function automatic lsm_op_t lsm_unpack(logic [WORD_W-1:0] w);
        lsm_op_t o;
        o.span_lo    = w[24:20];
        o.base_r     = w[19:15];
        o.span_hi    = w[14:10];
        o.spec_sel   = w[9:6];
        o.is_store   = w[5];
        o.skip_first = w[4];
        o.down       = w[3];
        o.upd_base   = w[2];
        return o;
    endfunction
endpackage

// File: rtl/lsm_decode.sv
module lsm_decode
    import lsm_pkg::*;
(
    input  lsm_op_t            op,
    input  logic [ADDR_W-1:0]  base,
    output logic [REG_N-1:0]   reg_mask,
    output logic [CNT_W-1:0]   count,
    output logic [ADDR_W-1:0]  start_addr,
    output logic [ADDR_W-1:0]  next_base,
    output logic               bad_enc
);
    logic [ADDR_W-1:0] span_bytes;

    for (genvar i = 0; i < REG_N; i++) begin : g_mask
        if (i < SPEC_LO) begin : g_span
            assign reg_mask[i] = (IDX_W'(i) >= op.span_lo) && (IDX_W'(i) <= op.span_hi);
        end else begin : g_spec
            assign reg_mask[i] = op.spec_sel[REG_N-1-i];
        end
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < REG_N; i++) count = count + CNT_W'(reg_mask[i]);
    end

    assign span_bytes = ADDR_W'(count) * ADDR_W'(STEP_B);

    always_comb begin
        if (op.down) begin
            next_base  = base - span_bytes;
            start_addr = base - span_bytes + (op.skip_first ? '0 : ADDR_W'(STEP_B));
        end else begin
            next_base  = base + span_bytes;
            start_addr = base + (op.skip_first ? ADDR_W'(STEP_B) : '0);
        end
    end

    assign bad_enc = op.upd_base & reg_mask[op.base_r];
endmodule

// File: rtl/lsm_pick.sv
module lsm_pick
    import lsm_pkg::*;
(
    input  logic [REG_N-1:0] pending,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = REG_N - 1; i >= 0; i--) begin
            if (pending[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  instr_valid,
    input  logic [WORD_W-1:0]     instr_word,
    output logic                  instr_ready,
    output logic [IDX_W-1:0]      rf_raddr,
    input  logic [WORD_W-1:0]     rf_rdata,
    output logic                  rf_we,
    output logic [IDX_W-1:0]      rf_waddr,
    output logic [WORD_W-1:0]     rf_wdata,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]     mem_wdata,
    input  logic [WORD_W-1:0]     mem_rdata,
    output logic                  busy,
    output logic                  done,
    output logic                  illegal
);
    lsm_state_e        state_q;
    lsm_op_t           op_in, op_q;
    logic [REG_N-1:0]  mask_in, mask_q, mask_left;
    logic [CNT_W-1:0]  cnt_in;
    logic [ADDR_W-1:0] start_in, nbase_in, addr_q, nbase_q;
    logic              bad_in, bad_q, done_q, ill_q;
    logic [IDX_W-1:0]  cur_idx;
    logic              cur_any, accept, hs;

    assign op_in = lsm_unpack(instr_word);

    lsm_decode u_dec (
        .op        (op_in),
        .base      (ADDR_W'(rf_rdata)),
        .reg_mask  (mask_in),
        .count     (cnt_in),
        .start_addr(start_in),
        .next_base (nbase_in),
        .bad_enc   (bad_in)
    );

    lsm_pick u_pick (
        .pending(mask_q),
        .idx    (cur_idx),
        .any    (cur_any)
    );

    assign instr_ready   = (state_q == ST_IDLE);
    assign accept        = instr_valid && instr_ready;
    assign busy          = !instr_ready;
    assign mem_req_valid = (state_q == ST_XFER) && cur_any;
    assign hs            = mem_req_valid && mem_req_ready;
    assign mem_we        = op_q.is_store;
    assign mem_addr      = addr_q;
    assign mem_wdata     = rf_rdata;
    assign rf_raddr      = instr_ready ? op_in.base_r : cur_idx;
    assign done          = done_q;
    assign illegal       = ill_q;

    always_comb begin
        mask_left = mask_q;
        mask_left[cur_idx] = 1'b0;
    end

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = cur_idx;
        rf_wdata = mem_rdata;
        if (state_q == ST_BASE) begin
            rf_we    = op_q.upd_base && !bad_q;
            rf_waddr = op_q.base_r;
            rf_wdata = WORD_W'(nbase_q);
        end else if (hs && !op_q.is_store) begin
            rf_we = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            mask_q  <= '0;
            addr_q  <= '0;
            nbase_q <= '0;
            bad_q   <= 1'b0;
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    op_q    <= op_in;
                    mask_q  <= mask_in;
                    addr_q  <= start_in;
                    nbase_q <= nbase_in;
                    bad_q   <= bad_in;
                    state_q <= (cnt_in != '0) ? ST_XFER : ST_BASE;
                end
                ST_XFER: if (hs) begin
                    mask_q <= mask_left;
                    addr_q <= addr_q + ADDR_W'(STEP_B);
                    if (mask_left == '0) state_q <= ST_BASE;
                end
                ST_BASE: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    ill_q   <= bad_q;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk
    import lsm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              instr_ready,
    input logic              rf_we,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done,
    input logic              illegal
);
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_we));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=> !mem_req_valid || (mem_addr == $past(mem_addr) + ADDR_W'(STEP_B)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_req_busy_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> busy && !instr_ready);

    p_store_no_rf_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_we |-> !rf_we);

    p_illegal_done_r8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> done);
endmodule

bind lsm_seq lsm_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .instr_ready  (instr_ready),
    .rf_we        (rf_we),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .busy         (busy),
    .done         (done),
    .illegal      (illegal)
);

// File: tb/lsm_seq_tb_top.sv
module lsm_seq_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, instr_valid, instr_ready, rf_we, mem_req_valid, mem_req_ready;
    logic        mem_we, busy, done, illegal;
    logic [31:0] instr_word, rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata;
    logic [4:0]  rf_raddr, rf_waddr;

    logic [31:0] tmem [128];
    logic [31:0] treg [32];
    logic [31:0] exp_mem [128];
    logic [31:0] exp_reg [32];
    logic        tb_init;
    logic [4:0]  init_ra;
    int          hs_cnt, stall_viol, cyc, checks, fails;
    logic [15:0] lfsr;
    logic        prev_stall;
    logic [31:0] prev_addr;
    localparam logic [31:0] BASE = 32'h100;

    lsm_seq dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_ready(instr_ready), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .illegal(illegal)
    );

    assign rf_rdata      = treg[rf_raddr];
    assign mem_rdata     = tmem[mem_addr[8:2]];
    assign mem_req_ready = lfsr[0] | lfsr[3];

    function automatic logic [31:0] reg_init(int i, logic [4:0] ra);
        return (i == int'(ra)) ? BASE : (32'hA000_0000 | (i << 8));
    endfunction

    always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    always @(posedge clk) begin
        if (tb_init) begin
            for (int i = 0; i < 128; i++) tmem[i] <= 32'h5000_0000 + i * 3;
            for (int i = 0; i < 32; i++) treg[i] <= reg_init(i, init_ra);
            hs_cnt <= 0;
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                hs_cnt <= hs_cnt + 1;
                if (mem_we) tmem[mem_addr[8:2]] <= mem_wdata;
            end
            if (rf_we) treg[rf_waddr] <= rf_wdata;
        end
        if (rst) begin
            stall_viol <= 0;
            prev_stall <= 1'b0;
        end else begin
            prev_stall <= mem_req_valid && !mem_req_ready;
            prev_addr  <= mem_addr;
            if (prev_stall && (!mem_req_valid || mem_addr != prev_addr)) stall_viol <= stall_viol + 1;
        end
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_case(bit ld, bit pre, bit dn, bit wb, logic [4:0] ra,
                            logic [4:0] rb, logic [4:0] re, logic [3:0] sp);
        logic [31:0] w, low, a;
        logic [31:0] sel;
        int n, k, c;
        bit got, bad, mem_ok, reg_ok;
        int mi, ri;
        w = '0;
        w[24:20] = rb; w[19:15] = ra; w[14:10] = re; w[9:6] = sp;
        w[5] = !ld; w[4] = pre; w[3] = dn; w[2] = wb;
        // R2: span bits 0..27, selection bit0->31, bit1->30, bit2->29, bit3->28
        sel = '0;
        for (int i = 0; i < 28; i++) sel[i] = (i >= int'(rb)) && (i <= int'(re));
        sel[31] = sp[0]; sel[30] = sp[1]; sel[29] = sp[2]; sel[28] = sp[3];
        n = 0;
        for (int i = 0; i < 32; i++) if (sel[i]) n++;
        for (int i = 0; i < 128; i++) exp_mem[i] = 32'h5000_0000 + i * 3;
        for (int i = 0; i < 32; i++) exp_reg[i] = reg_init(i, ra);
        // R4/R5: lowest address used first
        if (!dn) low = BASE + (pre ? 32'd4 : 32'd0);
        else     low = BASE - 32'(4 * (n - 1)) - (pre ? 32'd4 : 32'd0);
        k = 0;
        for (int r = 0; r < 32; r++) begin
            if (sel[r]) begin
                a = low + 32'(4 * k);
                if (ld) exp_reg[r] = exp_mem[a[8:2]];
                else    exp_mem[a[8:2]] = reg_init(r, ra);
                k++;
            end
        end
        bad = wb && sel[ra];
        if (wb && !bad) exp_reg[ra] = dn ? BASE - 32'(4 * n) : BASE + 32'(4 * n);

        @(negedge clk); tb_init = 1'b1; init_ra = ra;
        @(negedge clk); tb_init = 1'b0;
        instr_word = w; instr_valid = 1'b1;
        @(negedge clk); instr_valid = 1'b0;
        if (n >= 3) begin
            // R10: word offered while busy must be ignored
            instr_word = ~w; instr_valid = 1'b1;
            @(negedge clk); instr_valid = 1'b0;
        end
        got = 0;
        for (c = 0; c < 3000; c++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        chk(got, "R10", "done seen", 32'(got), 32'd1);
        if (!got) return;
        mem_ok = 1; mi = 0;
        for (int i = 0; i < 128; i++) if (mem_ok && tmem[i] !== exp_mem[i]) begin mem_ok = 0; mi = i; end
        reg_ok = 1; ri = 0;
        for (int i = 0; i < 32; i++) if (reg_ok && treg[i] !== exp_reg[i]) begin reg_ok = 0; ri = i; end
        if (ld) chk(mem_ok, "R6", "memory after load", tmem[mi], exp_mem[mi]);
        else    chk(mem_ok, "R3 R4 R5 R6", $sformatf("store mem word %0d w=%h", mi, w), tmem[mi], exp_mem[mi]);
        chk(reg_ok, wb ? "R7 R8" : "R3 R6", $sformatf("reg %0d w=%h", ri, w), treg[ri], exp_reg[ri]);
        chk(hs_cnt == n, "R2 R3", $sformatf("transfer count w=%h", w), 32'(hs_cnt), 32'(n));
        chk(illegal == bad, "R8", "illegal flag", 32'(illegal), 32'(bad));
        @(negedge clk);
        chk(!done && !busy, "R10", "done single cycle, idle", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        checks = 0; fails = 0; cyc = 0;
        lfsr = 16'hACE1; tb_init = 1'b0; init_ra = 5'd2;
        instr_valid = 1'b0; instr_word = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(instr_ready && !busy && !done && !mem_req_valid && !illegal, "R10", "reset state",
            {27'd0, instr_ready, busy, done, mem_req_valid, illegal}, 32'h10);
        // R1: all mode-bit combinations, both directions of transfer
        for (int m = 0; m < 8; m++) begin
            for (int ld = 0; ld < 2; ld++) begin
                run_case(ld[0], m[2], m[1], m[0], 5'd2, 5'd8,  5'd12, 4'b0000);
                run_case(ld[0], m[2], m[1], m[0], 5'd2, 5'd31, 5'd31, 4'b1011);
                run_case(ld[0], m[2], m[1], m[0], 5'd2, 5'd20, 5'd27, 4'b1111);
                run_case(ld[0], m[2], m[1], m[0], 5'd2, 5'd31, 5'd31, 4'b0000);
                run_case(ld[0], m[2], m[1], m[0], 5'd2, 5'd10, 5'd10, 4'b0100);
            end
        end
        // R8: base inside the list with update enabled
        run_case(1'b0, 1'b0, 1'b0, 1'b1, 5'd9,  5'd8,  5'd12, 4'b0000);
        run_case(1'b1, 1'b1, 1'b1, 1'b1, 5'd9,  5'd8,  5'd12, 4'b0000);
        run_case(1'b0, 1'b1, 1'b1, 1'b1, 5'd31, 5'd31, 5'd31, 4'b0001);
        // R8: base in list without update is legal
        run_case(1'b0, 1'b0, 1'b0, 1'b0, 5'd9,  5'd8,  5'd12, 4'b0000);
        // R9: stalled requests held
        chk(stall_viol == 0, "R9", "stalled request changed", 32'(stall_viol), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule